// File: doc/BRIEF.md
# External Interrupt Line Controller

This block takes four asynchronous interrupt request pins from outside the chip and turns each into a clean, qualified request for a downstream interrupt encoder. Each pin is first brought into the clock domain by a short flop chain. The line's programmed sense type then decides how the pin is interpreted: as an active-high level, an active-low level, a rising edge or a falling edge. Edge events are held in a per-line latch until software acknowledges them.

All configuration sits in a single 32-bit control word. The word is written whole through a simple write strobe and can always be read back. The same word also carries two further bits. One is a master enable that gates all four lines at once. The other selects how the critical interrupt is routed, and is presented as a plain output.

A typical start-up sequence writes the word once. It keeps the sense fields, writes ones to all four acknowledge bits to discard stale events, sets the master enable, and leaves every per-line enable at zero. Lines are then enabled one by one as their handlers are installed.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000000, every request output is 0, and both the master-enable and critical-route outputs are 0.
- R2: A write stores the implemented bits: the sense fields [23:16], master enable [12], per-line enables [11:8] and critical route [0]. These bits read back as written. Every other bit, including the acknowledge bits [27:24], reads back 0.
- R3: For line n, the 2-bit sense field sits at bits [23-2n:22-2n]. Code 0 is active-high level and code 3 is active-low level. For a level code, the request follows the pin without latching. A pin change applied before clock edge k shows at the request after edge k+1.
- R4: Sense code 1 selects rising edge. A 0-to-1 pin transition applied before edge k sets the line's latch at edge k+2. The request then stays high after the pin returns low.
- R5: Sense code 2 selects falling edge. A 1-to-0 pin transition sets the latch, and a rising transition does not.
- R6: Writing a one to bit (27-n) clears the latch of line n at that write's clock edge. Writing a zero there leaves it set. An acknowledge for one line does not touch the others.
- R7: A write that changes the sense field of line n clears that line's latch.
- R8: Bit (11-n) enables line n, with 1 meaning enabled. A disabled line requests 0, but its latch is kept, so the request comes back when the line is re-enabled.
- R9: Bit 12 is the master enable. While it is 0, all four requests are 0. Bit 12 drives the master-enable output and bit 0 drives the critical-route output.
- R10: For a line programmed with a level code, writing its acknowledge bit has no effect on its request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data |
| pin_i | input | 4 | Asynchronous external request pins, bit n is line n |
| req_o | output | 4 | Qualified request per line toward the encoder |
| master_en_o | output | 1 | Master external enable (bit 12) |
| crit_route_o | output | 1 | Critical interrupt routing select (bit 0) |

## Verification
The latch assertions take for granted that an acknowledge write does not arrive in the same cycle as a newly detected edge on the same line. In that case the set wins and the clear is not visible. The stimulus always lets the pins settle for several cycles before writing an acknowledge. The sweep drives each pin only from negative clock edges, and holds each level long enough for the flop chain and the edge history to catch up. So every detected edge corresponds to exactly one pin transition.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int CTRL_W     = 32;
    localparam int NUM_LINES  = 4;
    localparam int SENSE_TOP  = 22;   // low bit of line 0 sense field
    localparam int ENABLE_TOP = 11;   // enable bit of line 0
    localparam int ACK_TOP    = 27;   // acknowledge bit of line 0
    localparam int MASTER_BIT = 12;
    localparam int CRIT_BIT   = 0;

    typedef enum logic [1:0] {
        SNS_LVL_HI = 2'd0,
        SNS_RISE   = 2'd1,
        SNS_FALL   = 2'd2,
        SNS_LVL_LO = 2'd3
    } sense_t;

    typedef struct packed {
        sense_t sense;
        logic   en;
    } line_cfg_t;

    function automatic int sense_lo(input int n);
        return SENSE_TOP - 2 * n;
    endfunction

    function automatic int enable_pos(input int n);
        return ENABLE_TOP - n;
    endfunction

    function automatic int ack_pos(input int n);
        return ACK_TOP - n;
    endfunction

    function automatic logic is_edge(input sense_t s);
        return (s == SNS_RISE) || (s == SNS_FALL);
    endfunction

    // Bits that hold state and read back.
    function automatic logic [CTRL_W-1:0] impl_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            m[sense_lo(n)]     = 1'b1;
            m[sense_lo(n) + 1] = 1'b1;
            m[enable_pos(n)]   = 1'b1;
        end
        m[MASTER_BIT] = 1'b1;
        m[CRIT_BIT]   = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= '0;
        else     chain_q[0] <= async_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '0;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [CTRL_W-1:0]         wr_data,
    output logic [CTRL_W-1:0]         rd_data,
    output line_cfg_t [NUM_LINES-1:0] cfg_o,
    output logic [NUM_LINES-1:0]      ack_o,
    output logic [NUM_LINES-1:0]      sense_chg_o,
    output logic                      master_o,
    output logic                      crit_o
);
    localparam logic [CTRL_W-1:0] MASK = impl_mask();

    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)        ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wr_data & MASK;
    end

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            localparam int LO = SENSE_TOP - 2 * g;
            localparam int EN = ENABLE_TOP - g;
            localparam int AK = ACK_TOP - g;
            assign cfg_o[g].sense   = sense_t'(ctrl_q[LO+1:LO]);
            assign cfg_o[g].en      = ctrl_q[EN];
            assign ack_o[g]         = wr_en & wr_data[AK];
            assign sense_chg_o[g]   = wr_en & (wr_data[LO+1:LO] != ctrl_q[LO+1:LO]);
        end
    endgenerate

    assign master_o = ctrl_q[MASTER_BIT];
    assign crit_o   = ctrl_q[CRIT_BIT];
    assign rd_data  = ctrl_q;
endmodule

// File: rtl/extirq_line.sv
module extirq_line
    import extirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_i,
    input  line_cfg_t cfg_i,
    input  logic      master_i,
    input  logic      ack_i,
    input  logic      sense_chg_i,
    output logic      req_o
);
    logic prev_q;
    logic latch_q;
    logic rise, fall, hit, level_act, edge_mode;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_i;
    end

    assign rise      = sync_i & ~prev_q;
    assign fall      = ~sync_i & prev_q;
    assign edge_mode = is_edge(cfg_i.sense);
    assign hit       = ((cfg_i.sense == SNS_RISE) & rise) |
                       ((cfg_i.sense == SNS_FALL) & fall);

    // Sense change first, then a new edge, then acknowledge.
    always_ff @(posedge clk) begin
        if (rst)              latch_q <= 1'b0;
        else if (sense_chg_i) latch_q <= 1'b0;
        else if (hit)         latch_q <= 1'b1;
        else if (ack_i)       latch_q <= 1'b0;
    end

    assign level_act = (cfg_i.sense == SNS_LVL_HI) ? sync_i : ~sync_i;
    assign req_o     = master_i & cfg_i.en & (edge_mode ? latch_q : level_act);

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !hit && !sense_chg_i) |=> !latch_q); // R6

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
        !edge_mode |-> !latch_q); // R10

    AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_q) |-> $past(edge_mode)); // R4

    AST_CHG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sense_chg_i |=> !latch_q); // R7
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CTRL_W-1:0]    wr_data,
    output logic [CTRL_W-1:0]    rd_data,
    input  logic [NUM_LINES-1:0] pin_i,
    output logic [NUM_LINES-1:0] req_o,
    output logic                 master_en_o,
    output logic                 crit_route_o
);
    localparam logic [CTRL_W-1:0] MASK = impl_mask();

    logic [NUM_LINES-1:0]      pin_sync;
    line_cfg_t [NUM_LINES-1:0] cfg;
    logic [NUM_LINES-1:0]      ack;
    logic [NUM_LINES-1:0]      sense_chg;

    extirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    extirq_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .cfg_o       (cfg),
        .ack_o       (ack),
        .sense_chg_o (sense_chg),
        .master_o    (master_en_o),
        .crit_o      (crit_route_o)
    );

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            extirq_line u_line (
                .clk         (clk),
                .rst         (rst),
                .sync_i      (pin_sync[g]),
                .cfg_i       (cfg[g]),
                .master_i    (master_en_o),
                .ack_i       (ack[g]),
                .sense_chg_i (sense_chg[g]),
                .req_o       (req_o[g])
            );
        end
    endgenerate

    AST_WR_READBACK: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == ($past(wr_data) & MASK))); // R2

    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (rst)
        !master_en_o |-> (req_o == '0)); // R9
endmodule

// File: tb/extirq_ctrl_tb.sv
module extirq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  pin = '0;
    logic [3:0]  req;
    logic        master_en, crit_route;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    extirq_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_i(pin), .req_o(req),
        .master_en_o(master_en), .crit_route_o(crit_route)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick(1);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Word with one line configured, field positions from R3, R8, R9.
    function automatic logic [31:0] cfg_word(input int n, input int code, input bit en, input bit mst);
        logic [31:0] w;
        w = '0;
        w[22-2*n +: 2] = code[1:0];
        w[11-n] = en;
        w[12] = mst;
        return w;
    endfunction

    initial begin
        logic [31:0] w;
        logic [3:0]  one;
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 req", {28'h0, req}, 32'h0);
        check("R1 master/crit", {30'h0, master_en, crit_route}, 32'h0);

        // R2 readback
        write(32'hFFFF_FFFF);
        check("R2 all ones", rd_data, 32'h00FF_1F01);
        write(32'h0A5A_5A5A);
        check("R2 pattern", rd_data, 32'h0A5A_5A5A & 32'h00FF_1F01);
        write(32'h0000_0000);
        check("R2 zero", rd_data, 32'h0);

        // Sweep every line and sense code (R3, R4, R5, R6, R10)
        for (int n = 0; n < 4; n++) begin
            for (int c = 0; c < 4; c++) begin
                one = 4'b1 << n;
                w = cfg_word(n, c, 1'b1, 1'b1);
                pin = '0;
                write(w | 32'h0F00_0000);
                tick(4);
                check($sformatf("R3 idle n=%0d c=%0d", n, c), {28'h0, req}, (c == 3) ? one : 4'h0);
                pin[n] = 1'b1;
                tick(2);
                check($sformatf("R3 rise+2 n=%0d c=%0d", n, c), {28'h0, req}, (c == 0) ? one : 4'h0);
                tick(1);
                check($sformatf("R4 rise+3 n=%0d c=%0d", n, c), {28'h0, req}, (c == 0 || c == 1) ? one : 4'h0);
                pin[n] = 1'b0;
                tick(4);
                check($sformatf("R5 fall n=%0d c=%0d", n, c), {28'h0, req}, (c == 0) ? 4'h0 : one);
                write(w | (32'h1 << (27 - n)));
                check($sformatf("R6/R10 ack n=%0d c=%0d", n, c), {28'h0, req}, (c == 3) ? one : 4'h0);
            end
        end

        // R6: zero in own ack bit, other line acknowledged
        w = cfg_word(1, 1, 1'b1, 1'b1);
        write(w | 32'h0F00_0000);
        pin[1] = 1'b1; tick(4); pin[1] = 1'b0; tick(4);
        write(w | (32'h1 << 25));
        check("R6 zero ack keeps latch", {28'h0, req}, 32'h2);

        // R8: enable gating keeps latch
        write(cfg_word(1, 1, 1'b0, 1'b1));
        check("R8 disabled", {28'h0, req}, 32'h0);
        write(w);
        check("R8 re-enabled", {28'h0, req}, 32'h2);

        // R7: sense change clears latch
        write(cfg_word(1, 2, 1'b1, 1'b1));
        check("R7 sense change", {28'h0, req}, 32'h0);
        write(w);
        check("R7 back to rising", {28'h0, req}, 32'h0);

        // R9: master gating and critical route
        pin = '0;
        write(cfg_word(0, 3, 1'b1, 1'b0));
        tick(3);
        check("R9 master off", {28'h0, req}, 32'h0);
        check("R9 master out off", {31'h0, master_en}, 32'h0);
        write(cfg_word(0, 3, 1'b1, 1'b1) | 32'h1);
        check("R9 master on", {28'h0, req}, 32'h1);
        check("R9 outputs", {30'h0, master_en, crit_route}, 32'h3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule